// File: doc/BRIEF.md
# Dual-Protocol Asynchronous Host Register Slave

This block lets an external 8-bit host processor read and write a small register file over an asynchronous strobe bus. One static input chooses which of two bus conventions the host uses. In the split-strobe convention there is a separate active-low read strobe and write strobe. In the data-strobe convention a single active-low data strobe frames every access, and a direction line gives read (1) or write (0). The two conventions share the same two strobe pins. The first pin is always the read strobe or the data strobe. The second pin is the write strobe or the direction line.

Chip select, both strobe pins, the address and the write data all pass through a two-stage synchroniser into the system clock. A three-state controller then runs each access through IDLE, SETTLE and ACK. While the controller is in ACK, an active-low ready output tells the host that it may end its cycle. The host is expected to hold its strobe until ready goes low. Read data leaves on a separate output bus, qualified by an output-enable, so that a pad ring can build the bidirectional data pins.

A sticky pending flag is set by an event pulse from the rest of the chip. The host clears it by writing 1 to it. The flag drives an active-low interrupt output through a global enable bit.

Controller transitions:
- IDLE→SETTLE: a synchronised strobe is seen while chip select is low.
- SETTLE→ACK: always, after one clock.
- ACK→IDLE: when the synchronised strobe is released.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, `rdy_n`=1, `data_oe`=0, `irq_n`=1, and every mapped register reads 0x00.
- R2: A read strobe applied with `cs_n` low produces `rdy_n`=0 exactly 4 clocks later: 2 clocks of synchronisation and 2 clocks of controller. While `rdy_n` is low and the strobe is still held, `data_oe`=1 and `data_out` carries the addressed register.
- R3: After the host releases the strobe, `data_oe` returns to 0 two clocks later and `rdy_n` returns to 1 three clocks later.
- R4: In split-strobe mode (`mode_moto`=0), `wr_rw` is an active-low write strobe. The data is committed to the register when the strobe is released (its rising edge).
- R5: In data-strobe mode (`mode_moto`=1), `rd_ds_n` is the data strobe. The level of `wr_rw` when the strobe starts selects the direction: 1 means read, 0 means write. A write is committed in the clock in which `rdy_n` falls. The acknowledge latency is the same as in R2.
- R6: In split-strobe mode, if both strobes are low when a cycle starts, the access is a read, and no register is written.
- R7: The register map is fixed. Address 0x00 is an 8-bit control register whose bit 0 is the global interrupt enable. Address 0x01 holds the pending flag in bit 0; its other bits read 0. Addresses 0x02 and 0x03 are 8-bit scratch registers.
- R8: A read of any other address returns 0x00. A write to any other address changes no register.
- R9: A one-clock `evt` pulse sets the pending flag. The flag stays set until a write to 0x01 with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R10: `irq_n` is 0 exactly when the pending flag and the enable bit are both 1.
- R11: When an `evt` pulse arrives in the same clock as a clearing write to 0x01, the flag remains set.
- R12: While `cs_n` is high, strobe activity is ignored: `rdy_n` stays high and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_moto | input | 1 | 0 = split strobes, 1 = data strobe plus direction line; static |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wr_rw | input | 1 | Write strobe, active low (mode 0), or direction line, 1 = read (mode 1) |
| addr | input | 8 | Register address |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data towards the host |
| data_oe | output | 1 | Output enable for the data pins |
| rdy_n | output | 1 | Active-low ready / acknowledge |
| evt | input | 1 | One-clock event pulse that sets the pending flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The clearing write to the pending flag and the event pulse that sets it can fall in the same clock. The clash is provoked in both modes. The event pulse is timed to the commit edge: the third clock after the strobe is released in split-strobe mode, and the edge on which acknowledge falls in data-strobe mode. The result is judged in two ways. First, a read-back must still show the flag set. Second, `irq_n` is compared on every clock against a model that applies set-over-clear precedence.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        HB_IDLE   = 2'd0,
        HB_SETTLE = 2'd1,
        HB_ACK    = 2'd2
    } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[i] <= INIT;
                    else        pipe[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[i] <= INIT;
                    else        pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1,
    parameter int SCR_BASE  = 2,
    parameter int SCR_N     = 2,
    parameter int GIE_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              evt,
    output logic              gie,
    output logic              pend
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic [DATA_W-1:0] ctrl_q;
    logic              pend_q;
    logic [DATA_W-1:0] scr_q [SCR_N];
    logic [SCR_N-1:0]  scr_wr_hit;
    logic              wr_mapped;
    logic              clr_req;

    assign clr_req = wr_en && (wr_addr == A_STAT) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (wr_en && wr_addr == A_CTRL)  ctrl_q <= wr_data;
    end

    // set has precedence over a clearing write in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (evt)     pend_q <= 1'b1;
        else if (clr_req) pend_q <= 1'b0;
    end

    generate
        for (genvar i = 0; i < SCR_N; i++) begin : g_scr
            localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(SCR_BASE + i);
            assign scr_wr_hit[i] = wr_en && (wr_addr == A_SCR);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             scr_q[i] <= '0;
                else if (scr_wr_hit[i]) scr_q[i] <= wr_data;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) rd_data = ctrl_q;
        if (rd_addr == A_STAT) rd_data = {{(DATA_W-1){1'b0}}, pend_q};
        for (int i = 0; i < SCR_N; i++) begin
            if (rd_addr == ADDR_W'(SCR_BASE + i)) rd_data = scr_q[i];
        end
    end

    always_comb begin
        wr_mapped = (wr_addr == A_CTRL) || (wr_addr == A_STAT) || (|scr_wr_hit);
    end

    assign gie  = ctrl_q[GIE_BIT];
    assign pend = pend_q;

    // R11: an event always leaves the flag set, even against a clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend_q);

    // R9: flag is sticky unless a clearing write arrives
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_req) |=> pend_q);

    // R8: writes to unmapped addresses leave the register state alone
    a_r8_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_mapped && !evt) |=> ($stable(ctrl_q) && $stable(pend_q)));
endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_moto,
    input  logic              cs_n_s,
    input  logic              rds_n_s,
    input  logic              wrw_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [DATA_W-1:0] rd_val,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              rdy_n,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    hb_state_e         st, st_nxt;
    logic              cyc_rd;
    logic              cyc_moto;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] wr_hold;
    logic              mode_sel;
    logic              split_rd;
    logic              split_wr;
    logic              strobe_on;
    logic              start_rd;

    // strobe decode on the synchronised pins
    always_comb begin
        mode_sel  = (st == HB_IDLE) ? mode_moto : cyc_moto;
        split_rd  = !cs_n_s && !rds_n_s;
        split_wr  = !cs_n_s && !wrw_s;
        strobe_on = mode_sel ? split_rd : (split_rd || split_wr);
        start_rd  = mode_moto ? wrw_s : split_rd;
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            HB_IDLE:   if (strobe_on)  st_nxt = HB_SETTLE;
            HB_SETTLE:                 st_nxt = HB_ACK;
            HB_ACK:    if (!strobe_on) st_nxt = HB_IDLE;
            default:                   st_nxt = HB_IDLE;
        endcase
    end

    // state register and cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= HB_IDLE;
            cyc_rd   <= 1'b0;
            cyc_moto <= 1'b0;
            cyc_addr <= '0;
            rd_q     <= '0;
            wr_hold  <= '0;
        end else begin
            st <= st_nxt;
            if (st == HB_IDLE && strobe_on) begin
                cyc_rd   <= start_rd;
                cyc_moto <= mode_moto;
                cyc_addr <= addr_s;
            end
            if (st == HB_SETTLE && cyc_rd) rd_q <= rd_val;
            if (strobe_on) wr_hold <= data_s;
        end
    end

    // outputs
    always_comb begin
        rdy_n    = (st != HB_ACK);
        data_oe  = (st == HB_ACK) && cyc_rd && strobe_on;
        data_out = data_oe ? rd_q : '0;
        wr_en    = ((st == HB_SETTLE) && cyc_moto && !cyc_rd) ||
                   ((st == HB_ACK) && !cyc_moto && !cyc_rd && !strobe_on);
        wr_addr  = cyc_addr;
        wr_data  = cyc_moto ? data_s : wr_hold;
    end

    // R2: acknowledge only starts while a strobe is still present
    a_r2_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(strobe_on));

    // R3: data is driven only while the host is acknowledged
    a_r3_oe_inside_ack: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !rdy_n);

    // R4: a commit is a single-clock event per cycle
    a_r4_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R12: a deselected idle controller never acknowledges
    a_r12_no_ack_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HB_IDLE && cs_n_s) |=> rdy_n);
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_moto,
    input  logic              cs_n,
    input  logic              rd_ds_n,
    input  logic              wr_rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rdy_n,
    input  logic              evt,
    output logic              irq_n
);
    localparam int SW = 3 + ADDR_W + DATA_W;
    localparam logic [SW-1:0] SYNC_INIT = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [SW-1:0]     sync_d, sync_q;
    logic              cs_n_s, rds_n_s, wrw_s;
    logic [ADDR_W-1:0] addr_s, cyc_addr, wr_addr;
    logic [DATA_W-1:0] data_s, rd_val, wr_data;
    logic              wr_en, gie, pend;

    assign sync_d = {cs_n, rd_ds_n, wr_rw, addr, data_in};

    hb_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sync_d), .q(sync_q)
    );

    assign {cs_n_s, rds_n_s, wrw_s, addr_s, data_s} = sync_q;

    hb_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto),
        .cs_n_s(cs_n_s), .rds_n_s(rds_n_s), .wrw_s(wrw_s),
        .addr_s(addr_s), .data_s(data_s), .rd_val(rd_val),
        .cyc_addr(cyc_addr), .rdy_n(rdy_n), .data_oe(data_oe),
        .data_out(data_out), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    hb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(cyc_addr), .rd_data(rd_val),
        .evt(evt), .gie(gie), .pend(pend)
    );

    assign irq_n = !(gie && pend);

    // R10: a request is raised one clock after an event when enabled
    a_r10_irq_follows_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && gie && !(wr_en && wr_data[0] == 1'b0 && wr_addr == '0)) |=> !irq_n);
endmodule

// File: tb/hostbus_slave_bench.sv
module hostbus_slave_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_moto = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_ds_n = 1'b1;
    logic       wr_rw = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic       rdy_n;
    logic       evt = 1'b0;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit busy = 1'b0;
    bit done = 1'b0;

    // behavioural register model
    logic [7:0] m_ctrl = '0;
    logic       m_pend = 1'b0;
    logic [7:0] m_scr [$];

    hostbus_slave u_hostbus_slave (
        .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .cs_n(cs_n),
        .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rdy_n(rdy_n), .evt(evt),
        .irq_n(irq_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h01: return {7'b0, m_pend};
            8'h02: return m_scr[0];
            8'h03: return m_scr[1];
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h00: m_ctrl = d;
            8'h01: if (d[0]) m_pend = 1'b0;
            8'h02: m_scr[0] = d;
            8'h03: m_scr[1] = d;
            default: ;
        endcase
    endfunction

    // every clock: interrupt against the model, idle bus quiet
    always @(negedge clk) begin
        if (rst_n) begin
            #(CLK_P/4);
            chk(irq_n == !(m_ctrl[0] && m_pend), "R10", "irq_n vs model",
                irq_n, !(m_ctrl[0] && m_pend));
            if (!busy)
                chk(rdy_n && !data_oe, "R12", "idle bus quiet",
                    {rdy_n, data_oe}, 2'b10);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "R1", "watchdog expired", cycles, 100000);
            finish_run();
        end
    end

    // one host access; called on a falling clock edge
    task automatic bus_cycle(input bit moto, input bit is_rd, input logic [7:0] a,
                             input logic [7:0] d, input bit both, input bit evt_hit,
                             output logic [7:0] rdat);
        int k = 0;
        busy = 1'b1;
        rdat = '0;
        mode_moto = moto;
        addr = a;
        data_in = d;
        cs_n = 1'b0;
        if (moto) begin
            wr_rw = is_rd;
            rd_ds_n = 1'b0;
        end else if (is_rd) begin
            rd_ds_n = 1'b0;
            if (both) wr_rw = 1'b0;
        end else begin
            wr_rw = 1'b0;
        end
        do begin
            @(negedge clk);
            k++;
            if (evt_hit && moto && !is_rd && k == 3) evt = 1'b1;
            if (k == 4) evt = 1'b0;
        end while (rdy_n && k < 10);
        chk(k == 4, moto ? "R5" : "R2", "ack latency", k, 4);
        if (is_rd) begin
            chk(data_oe == 1'b1, "R2", "oe during ack", data_oe, 1);
            rdat = data_out;
        end else if (moto) begin
            m_write(a, d);
            if (evt_hit) m_pend = 1'b1;
        end
        cs_n = 1'b1;
        rd_ds_n = 1'b1;
        wr_rw = 1'b1;
        @(negedge clk);
        chk(rdy_n == 1'b0, "R3", "ack held 1", rdy_n, 0);
        if (is_rd) chk(data_oe == 1'b1, "R3", "oe held 1", data_oe, 1);
        @(negedge clk);
        chk(rdy_n == 1'b0, "R3", "ack held 2", rdy_n, 0);
        chk(data_oe == 1'b0, "R3", "oe off", data_oe, 0);
        if (evt_hit && !moto && !is_rd) evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
        chk(rdy_n == 1'b1, "R3", "ack released", rdy_n, 1);
        if (!moto && !is_rd) begin
            m_write(a, d);
            if (evt_hit) m_pend = 1'b1;
        end
        busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_expect(input bit moto, input logic [7:0] a, input string tag);
        logic [7:0] r;
        logic [7:0] e;
        e = m_read(a);
        bus_cycle(moto, 1'b1, a, 8'h00, 1'b0, 1'b0, r);
        chk(r == e, tag, "read data", r, e);
    endtask

    task automatic wr(input bit moto, input logic [7:0] a, input logic [7:0] d,
                      input bit evt_hit);
        logic [7:0] r;
        bus_cycle(moto, 1'b0, a, d, 1'b0, evt_hit, r);
    endtask

    task automatic pulse_evt();
        evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
        m_pend = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        m_scr.push_back(8'h00);
        m_scr.push_back(8'h00);
        repeat (3) @(negedge clk);
        chk(rdy_n == 1'b1 && data_oe == 1'b0 && irq_n == 1'b1, "R1", "reset outputs",
            {rdy_n, data_oe, irq_n}, 3'b101);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) rd_expect(1'b0, 8'(a), "R1");

        // R4: split-strobe write committed on release, read back
        wr(1'b0, 8'h02, 8'hA5, 1'b0);
        rd_expect(1'b0, 8'h02, "R4");
        // R5: data-strobe write and read
        wr(1'b1, 8'h03, 8'h3C, 1'b0);
        rd_expect(1'b1, 8'h03, "R5");
        rd_expect(1'b1, 8'h02, "R5");
        // R7: control register keeps all bits
        wr(1'b0, 8'h00, 8'hF0, 1'b0);
        rd_expect(1'b0, 8'h00, "R7");
        wr(1'b1, 8'h00, 8'h01, 1'b0);
        rd_expect(1'b1, 8'h00, "R7");

        // R9 / R10: event raises the flag and the request
        pulse_evt();
        chk(irq_n == 1'b0, "R10", "irq asserted", irq_n, 0);
        rd_expect(1'b0, 8'h01, "R9");
        wr(1'b0, 8'h01, 8'hFE, 1'b0);
        rd_expect(1'b0, 8'h01, "R9");
        chk(irq_n == 1'b0, "R9", "flag stays after write 0", irq_n, 0);
        wr(1'b1, 8'h01, 8'h01, 1'b0);
        rd_expect(1'b1, 8'h01, "R9");
        chk(irq_n == 1'b1, "R9", "flag cleared", irq_n, 1);
        // R10: masked request
        wr(1'b0, 8'h00, 8'h00, 1'b0);
        pulse_evt();
        chk(irq_n == 1'b1, "R10", "masked irq", irq_n, 1);
        wr(1'b0, 8'h00, 8'h01, 1'b0);
        chk(irq_n == 1'b0, "R10", "unmasked irq", irq_n, 0);
        wr(1'b0, 8'h01, 8'h01, 1'b0);

        // R11: event in the clearing clock, both modes
        wr(1'b0, 8'h01, 8'h01, 1'b1);
        rd_expect(1'b0, 8'h01, "R11");
        chk(irq_n == 1'b0, "R11", "split mode set wins", irq_n, 0);
        wr(1'b1, 8'h01, 8'h01, 1'b1);
        rd_expect(1'b1, 8'h01, "R11");
        chk(irq_n == 1'b0, "R11", "strobe mode set wins", irq_n, 0);
        wr(1'b1, 8'h01, 8'h01, 1'b0);

        // R8: unmapped space
        wr(1'b0, 8'h80, 8'hFF, 1'b0);
        wr(1'b1, 8'h04, 8'h77, 1'b0);
        rd_expect(1'b0, 8'h80, "R8");
        rd_expect(1'b1, 8'h04, "R8");
        rd_expect(1'b0, 8'h00, "R8");
        rd_expect(1'b0, 8'h02, "R8");
        rd_expect(1'b0, 8'h03, "R8");

        // R6: both split strobes low behaves as a read
        bus_cycle(1'b0, 1'b1, 8'h02, 8'h11, 1'b1, 1'b0, r);
        chk(r == 8'hA5, "R6", "both-low returns read", r, 8'hA5);
        rd_expect(1'b0, 8'h02, "R6");

        // R12: strobes while deselected
        mode_moto = 1'b0;
        addr = 8'h02;
        data_in = 8'hEE;
        wr_rw = 1'b0;
        rd_ds_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(rdy_n == 1'b1, "R12", "no ack when deselected", rdy_n, 1);
        end
        wr_rw = 1'b1;
        rd_ds_n = 1'b1;
        repeat (4) @(negedge clk);
        rd_expect(1'b0, 8'h02, "R12");

        finish_run();
    end
endmodule